// File: doc/BRIEF.md
# Handheld LCD Pixel Capture Front-End

This block sits on the native LCD video stream of a handheld console and turns it into pixel writes for an external frame buffer. It runs entirely on the console's continuous pixel clock. It samples vertical sync, horizontal sync and a 4-bit data bus on every rising edge. Lines are counted from the vertical sync rise, and clock pulses are counted from each horizontal sync rise. Each pixel is rebuilt from three colour nibbles that arrive in a six-clock slot, with an idle clock after each nibble.

For every pixel in the active window the block issues a single-cycle write strobe. The strobe carries the 12-bit colour, the X/Y position and a linear address. A mode input picks between two formats. The handheld format has fixed geometry and offsets. The larger legacy-console format has fixed geometry and horizontal and vertical offsets that come from configuration inputs. Both the mode and the offsets are captured into registers at each frame start.

Top module: `lcdcap_top`

## Requirements
- R1: After reset `wr_en` is low. Nothing is written until a vertical sync rise and then a horizontal sync rise have been seen.
- R2: The first horizontal sync rise sampled on or after the vertical sync rise edge is line 0, and each later rise adds one. Lines VSTART to VSTART+HEIGHT-1 are active, and their row is `wr_y` = line - VSTART.
- R3: A horizontal sync rise sampled before the vertical sync rise produces no writes, even when its data window runs after that rise.
- R4: Horizontal timing counts clock indices, where the edge at which horizontal sync is first sampled high is index 0. For pixel k, red is sampled at index HSTART+6k, green at HSTART+6k+2 and blue at HSTART+6k+4. The data at the three idle indices of each slot has no effect.
- R5: Each nibble takes `pix_data[3]` as its MSB and `pix_data[0]` as its LSB. `wr_pixel` is {red, green, blue}, with red in bits 11:8 and blue in bits 3:0.
- R6: `wr_en` is a one-cycle pulse that is visible right after the edge at which a blue nibble of an active row is sampled. `wr_x`, `wr_y`, `wr_addr` and `wr_pixel` are valid with it.
- R7: `wr_addr` equals `wr_y` * WIDTH + `wr_x`, where WIDTH is the width of the current mode.
- R8: Each active line yields exactly WIDTH writes, for x = 0 to WIDTH-1. Lines past the active rows and slots past the last pixel write nothing.
- R9: `mode_sel` (0 = handheld, 1 = legacy) is captured at the vertical sync rise. In handheld mode the geometry and offsets come from parameters. In legacy mode the width and height come from parameters, and HSTART and VSTART are taken from `cfg_hstart` and `cfg_vstart` at that rise. Later changes to these inputs have no effect until the next rise.
- R10: A vertical sync rise ends the current frame. No write appears in the cycle after it, and a line in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, also the system clock |
| rst_n | input | 1 | Active-low reset |
| vsync | input | 1 | Vertical sync, rising edge starts a frame |
| hsync | input | 1 | Horizontal sync, rising edge starts a line |
| pix_data | input | 4 | Sub-pixel colour nibble |
| mode_sel | input | 1 | 0 handheld format, 1 legacy format |
| cfg_hstart | input | HCNT_W | Legacy-mode horizontal start index |
| cfg_vstart | input | LINE_W | Legacy-mode first active line |
| wr_en | output | 1 | Single-cycle pixel write strobe |
| wr_x | output | X_W | Pixel column |
| wr_y | output | Y_W | Pixel row |
| wr_addr | output | ADDR_W | Linear frame buffer address |
| wr_pixel | output | 12 | R4G4B4 colour |

## Verification
The bench builds the block with a tiny handheld geometry: 3x2 pixels, horizontal start 7 and one leading blank line. The legacy geometry is 4x3, and its offsets are supplied at run time. With lines only a few dozen clocks long, every pixel of every frame can be checked for colour, address, position and exact write cycle. The same short frames also reach the rarer orderings: a line that starts before vertical sync, horizontal and vertical sync rising on the same edge, an offset changed in the middle of a frame, and a frame cut off partway through a pixel slot.

// File: rtl/lcdcap_pkg.sv
package lcdcap_pkg;

    localparam int NIB_W = 4;
    localparam int PIX_W = 3 * NIB_W;

    typedef enum logic [2:0] {
        PH_RED  = 3'd0,
        PH_GAP0 = 3'd1,
        PH_GRN  = 3'd2,
        PH_GAP1 = 3'd3,
        PH_BLU  = 3'd4,
        PH_GAP2 = 3'd5
    } slot_ph_e;

    function automatic slot_ph_e ph_next(input slot_ph_e p);
        case (p)
            PH_RED:  return PH_GAP0;
            PH_GAP0: return PH_GRN;
            PH_GRN:  return PH_GAP1;
            PH_GAP1: return PH_BLU;
            PH_BLU:  return PH_GAP2;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/lcdcap_frame.sv
module lcdcap_frame
    import lcdcap_pkg::*;
#(
    parameter int GG_W      = 160,
    parameter int GG_H      = 144,
    parameter int GG_HSTART = 533,
    parameter int GG_VSTART = 0,
    parameter int LG_W      = 256,
    parameter int LG_H      = 192,
    parameter int LINE_W    = 9,
    parameter int HCNT_W    = 12,
    parameter int X_W       = 8,
    parameter int Y_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              hsync,
    input  logic              mode_sel,
    input  logic [HCNT_W-1:0] cfg_hstart,
    input  logic [LINE_W-1:0] cfg_vstart,
    output logic              vs_rise,
    output logic              hs_rise,
    output logic              row_active,
    output logic [Y_W-1:0]    row_y,
    output logic [X_W:0]      act_width,
    output logic [HCNT_W-1:0] act_hstart
);

    localparam logic [LINE_W:0]   GG_H_L   = (LINE_W+1)'(GG_H);
    localparam logic [LINE_W:0]   LG_H_L   = (LINE_W+1)'(LG_H);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    typedef struct packed {
        logic              vs_prev;
        logic              hs_prev;
        logic              armed;
        logic              legacy;
        logic [LINE_W-1:0] line;
        logic [HCNT_W-1:0] hstart;
        logic [LINE_W-1:0] vstart;
    } frm_t;

    frm_t q, d;
    logic [LINE_W-1:0] rel_line;
    logic [LINE_W:0]   height;

    assign vs_rise = vsync & ~q.vs_prev;
    assign hs_rise = hsync & ~q.hs_prev;

    always_comb begin
        d         = q;
        d.vs_prev = vsync;
        d.hs_prev = hsync;
        if (vs_rise) begin
            d.legacy = mode_sel;
            d.hstart = mode_sel ? cfg_hstart : HCNT_W'(GG_HSTART);
            d.vstart = mode_sel ? cfg_vstart : LINE_W'(GG_VSTART);
            d.armed  = 1'b0;
            d.line   = '0;
        end
        if (hs_rise) begin
            if (d.armed) begin
                d.line = (q.line == LINE_MAX) ? q.line : q.line + 1'b1;
            end else begin
                d.armed = 1'b1;
                d.line  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign height     = q.legacy ? LG_H_L : GG_H_L;
    assign act_width  = q.legacy ? (X_W+1)'(LG_W) : (X_W+1)'(GG_W);
    assign act_hstart = q.hstart;
    assign rel_line   = q.line - q.vstart;
    assign row_y      = rel_line[Y_W-1:0];
    assign row_active = q.armed && (q.line >= q.vstart) && ({1'b0, rel_line} < height);

    AST_VS_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_rise && !hs_rise) |=> !q.armed); // R10

    AST_FIRST_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_rise && (vs_rise || !q.armed)) |=> (q.armed && q.line == '0)); // R2

endmodule

// File: rtl/lcdcap_slot.sv
module lcdcap_slot
    import lcdcap_pkg::*;
#(
    parameter int HCNT_W = 12,
    parameter int X_W    = 8,
    parameter int Y_W    = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vs_rise,
    input  logic              hs_rise,
    input  logic              row_active,
    input  logic [Y_W-1:0]    row_y,
    input  logic [X_W:0]      width,
    input  logic [HCNT_W-1:0] hstart,
    input  logic [NIB_W-1:0]  nib,
    output logic              wr_en,
    output logic [X_W-1:0]    wr_x,
    output logic [Y_W-1:0]    wr_y,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PIX_W-1:0]  wr_pixel
);

    localparam logic [HCNT_W-1:0] HCNT_MAX = '1;

    typedef struct packed {
        logic [HCNT_W-1:0] hcnt;
        logic              in_line;
        slot_ph_e          ph;
        logic [X_W-1:0]    x;
        logic [NIB_W-1:0]  red;
        logic [NIB_W-1:0]  grn;
        logic              we;
        logic [X_W-1:0]    ox;
        logic [Y_W-1:0]    oy;
        logic [ADDR_W-1:0] oaddr;
        logic [PIX_W-1:0]  opix;
    } slot_t;

    slot_t    q, d;
    logic     at_start, live;
    slot_ph_e ph_cur;
    logic [X_W-1:0] x_cur;
    logic     last_x;

    assign at_start = !hs_rise && !q.in_line && (q.hcnt == hstart);
    assign live     = at_start || q.in_line;
    assign ph_cur   = at_start ? PH_RED : q.ph;
    assign x_cur    = at_start ? '0 : q.x;
    assign last_x   = ({1'b0, x_cur} == (width - (X_W+1)'(1)));

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.hcnt = hs_rise ? HCNT_W'(1) : ((q.hcnt == HCNT_MAX) ? q.hcnt : q.hcnt + 1'b1);
        if (hs_rise || vs_rise) begin
            d.in_line = 1'b0;
            d.ph      = PH_RED;
            d.x       = '0;
        end else if (live) begin
            d.in_line = 1'b1;
            d.ph      = ph_next(ph_cur);
            d.x       = x_cur;
            case (ph_cur)
                PH_RED: d.red = nib;
                PH_GRN: d.grn = nib;
                PH_BLU: begin
                    d.we    = row_active;
                    d.ox    = x_cur;
                    d.oy    = row_y;
                    d.oaddr = ADDR_W'(row_y) * ADDR_W'(width) + ADDR_W'(x_cur);
                    d.opix  = {q.red, q.grn, nib};
                end
                PH_GAP2: begin
                    if (last_x) begin
                        d.in_line = 1'b0;
                    end else begin
                        d.x = x_cur + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.hcnt <= HCNT_MAX;
        end else begin
            q <= d;
        end
    end

    assign wr_en    = q.we;
    assign wr_x     = q.ox;
    assign wr_y     = q.oy;
    assign wr_addr  = q.oaddr;
    assign wr_pixel = q.opix;

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we); // R6

    AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> ({1'b0, q.ox} < width)); // R8

    AST_VS_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> !q.we); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.we && q.ox != '0 && $past(q.we, 6)) |-> (q.oaddr == $past(q.oaddr, 6) + ADDR_W'(1))); // R7

endmodule

// File: rtl/lcdcap_top.sv
module lcdcap_top
    import lcdcap_pkg::*;
#(
    parameter int GG_W      = 160,
    parameter int GG_H      = 144,
    parameter int GG_HSTART = 533,
    parameter int GG_VSTART = 0,
    parameter int LG_W      = 256,
    parameter int LG_H      = 192,
    parameter int LINE_W    = 9,
    parameter int HCNT_W    = 12,
    localparam int MAX_W    = (GG_W > LG_W) ? GG_W : LG_W,
    localparam int MAX_H    = (GG_H > LG_H) ? GG_H : LG_H,
    localparam int MAX_A    = (GG_W*GG_H > LG_W*LG_H) ? GG_W*GG_H : LG_W*LG_H,
    localparam int X_W      = (MAX_W > 2) ? $clog2(MAX_W) : 1,
    localparam int Y_W      = (MAX_H > 2) ? $clog2(MAX_H) : 1,
    localparam int ADDR_W   = (MAX_A > 2) ? $clog2(MAX_A) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              hsync,
    input  logic [3:0]        pix_data,
    input  logic              mode_sel,
    input  logic [HCNT_W-1:0] cfg_hstart,
    input  logic [LINE_W-1:0] cfg_vstart,
    output logic              wr_en,
    output logic [X_W-1:0]    wr_x,
    output logic [Y_W-1:0]    wr_y,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [11:0]       wr_pixel
);

    logic              vs_rise, hs_rise, row_active;
    logic [Y_W-1:0]    row_y;
    logic [X_W:0]      act_width;
    logic [HCNT_W-1:0] act_hstart;

    lcdcap_frame #(
        .GG_W(GG_W), .GG_H(GG_H), .GG_HSTART(GG_HSTART), .GG_VSTART(GG_VSTART),
        .LG_W(LG_W), .LG_H(LG_H), .LINE_W(LINE_W), .HCNT_W(HCNT_W),
        .X_W(X_W), .Y_W(Y_W)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync),
        .mode_sel(mode_sel), .cfg_hstart(cfg_hstart), .cfg_vstart(cfg_vstart),
        .vs_rise(vs_rise), .hs_rise(hs_rise), .row_active(row_active),
        .row_y(row_y), .act_width(act_width), .act_hstart(act_hstart)
    );

    lcdcap_slot #(
        .HCNT_W(HCNT_W), .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W)
    ) u_slot (
        .clk(clk), .rst_n(rst_n), .vs_rise(vs_rise), .hs_rise(hs_rise),
        .row_active(row_active), .row_y(row_y), .width(act_width),
        .hstart(act_hstart), .nib(pix_data),
        .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y), .wr_addr(wr_addr), .wr_pixel(wr_pixel)
    );

endmodule

// File: tb/sim_lcdcap_top.sv
module sim_lcdcap_top;

    localparam int GW = 3, GH = 2, GHS = 7, GVS = 1;
    localparam int LW = 4, LH = 3;
    localparam int LINE_W = 6, HCNT_W = 6;
    localparam int X_W = 2, Y_W = 2, ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vsync = 1'b0, hsync = 1'b0, mode_sel = 1'b0;
    logic [3:0]        pix_data = '0;
    logic [HCNT_W-1:0] cfg_hstart = '0;
    logic [LINE_W-1:0] cfg_vstart = '0;
    logic              wr_en;
    logic [X_W-1:0]    wr_x;
    logic [Y_W-1:0]    wr_y;
    logic [ADDR_W-1:0] wr_addr;
    logic [11:0]       wr_pixel;

    int checks = 0, fails = 0, edge_n = 0, frame_writes = 0;
    int e_w = GW, e_h = GH, e_hs = GHS, e_vs = GVS;
    int line_edge [0:15];
    bit finished = 1'b0;

    lcdcap_top #(
        .GG_W(GW), .GG_H(GH), .GG_HSTART(GHS), .GG_VSTART(GVS),
        .LG_W(LW), .LG_H(LH), .LINE_W(LINE_W), .HCNT_W(HCNT_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync), .pix_data(pix_data),
        .mode_sel(mode_sel), .cfg_hstart(cfg_hstart), .cfg_vstart(cfg_vstart),
        .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y), .wr_addr(wr_addr), .wr_pixel(wr_pixel)
    );

    always #10 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nib(input int l, input int k, input int c);
        return (l * 5 + k * 3 + c * 7 + 1) & 15;
    endfunction

    // monitor: every write checked for range, address, colour and exact cycle
    always @(negedge clk) begin
        if (rst_n && wr_en && !finished) begin
            int row, x, y, epix;
            x = int'(wr_x);
            y = int'(wr_y);
            row = y + e_vs;
            frame_writes++;
            chk(x < e_w && y < e_h, "R8 position in window", x * 100 + y, -1);
            chk(int'(wr_addr) == y * e_w + x, "R7 address", int'(wr_addr), y * e_w + x);
            epix = (nib(row, x, 0) << 8) | (nib(row, x, 1) << 4) | nib(row, x, 2);
            chk(int'(wr_pixel) == epix, "R5 pixel nibbles", int'(wr_pixel), epix);
            if (row < 16)
                chk(edge_n == line_edge[row] + e_hs + 4 + 6 * x, "R4/R6 write cycle",
                    edge_n, line_edge[row] + e_hs + 4 + 6 * x);
        end
    end

    task automatic drive_line(input int l, input int len, input int vs_at);
        for (int t = 0; t < len; t++) begin
            int rel;
            @(negedge clk);
            if (t == 0 && l >= 0 && l < 16) line_edge[l] = edge_n + 1;
            hsync = (t < 3);
            if (t == vs_at) vsync = 1'b1;
            if (vs_at >= 0 && t == vs_at + 5) vsync = 1'b0;
            rel = t - e_hs;
            if (rel >= 0 && (rel % 6) == 0)      pix_data = 4'(nib(l, rel / 6, 0));
            else if (rel >= 0 && (rel % 6) == 2) pix_data = 4'(nib(l, rel / 6, 1));
            else if (rel >= 0 && (rel % 6) == 4) pix_data = 4'(nib(l, rel / 6, 2));
            else                                 pix_data = 4'((t * 11 + 3) & 15);
        end
    endtask

    // vsmode: 0 separate pulse, 1 same edge as line 0, 2 inside a line begun earlier
    task automatic frame(input bit m, input int chs, input int cvs, input int vsmode,
                         input int nlines, input int last_len, input bit mid_chg,
                         input int exp_cnt, input string req);
        mode_sel   = m;
        cfg_hstart = HCNT_W'(chs);
        cfg_vstart = LINE_W'(cvs);
        e_w  = m ? LW : GW;
        e_h  = m ? LH : GH;
        e_hs = m ? chs : GHS;
        e_vs = m ? cvs : GVS;
        frame_writes = 0;
        if (vsmode == 0) begin
            @(negedge clk); vsync = 1'b1; hsync = 1'b0;
            repeat (2) @(negedge clk);
            vsync = 1'b0;
        end else if (vsmode == 2) begin
            drive_line(99, e_hs + 6 * (e_w + 1) + 4, 4); // R3 line begun before vsync
        end
        for (int l = 0; l < nlines; l++) begin
            int len;
            if (mid_chg && l == 1) cfg_hstart = HCNT_W'(3);
            len = (l == nlines - 1 && last_len > 0) ? last_len : e_hs + 6 * (e_w + 1) + 4;
            drive_line(l, len, (vsmode == 1 && l == 0) ? 0 : -1);
        end
        if (last_len == 0) repeat (3) @(negedge clk);
        chk(frame_writes == exp_cnt, req, frame_writes, exp_cnt);
    endtask

    initial begin
        repeat (4) begin
            @(negedge clk);
            chk(wr_en == 1'b0, "R1 idle in reset", int'(wr_en), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_en == 1'b0, "R1 idle after reset", int'(wr_en), 0);
        frame_writes = 0;
        drive_line(-1, 40, -1);
        repeat (3) @(negedge clk);
        chk(frame_writes == 0, "R1 no write before first vsync", frame_writes, 0);

        frame(1'b0, 0, 0, 0, GVS + GH + 1, 0, 1'b0, GW * GH, "R2/R8 handheld frame count");
        frame(1'b1, 10, 2, 1, 2 + LH + 1, 0, 1'b0, LW * LH, "R9 legacy frame, R2 coincident sync");
        frame(1'b0, 0, 0, 2, GVS + GH + 1, 0, 1'b0, GW * GH, "R3 early line ignored");
        frame(1'b1, 12, 0, 2, LH + 1, 0, 1'b1, LW * LH, "R9 latched offsets, mid-frame change");
        frame(1'b0, 0, 0, 0, 2, GHS + 8, 1'b0, 1, "R10 frame cut mid-slot");
        frame(1'b0, 0, 0, 0, GVS + GH + 1, 0, 1'b0, GW * GH, "R10 frame after cut");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule